// File: doc/BRIEF.md
# PCI Command and Status Register with Parity-Error Tracking

This block holds the 32-bit command/status word of a PCI function's configuration header. The lower half carries the command controls, and the upper half carries sticky status flags. A host reaches the word through configuration read and write cycles at byte offset 0x04. Access is allowed only while the interface's host-mode field selects PCI operation. Writes follow the four byte enables, and the status flags are cleared by writing a one to them.

Three command bits drive control outputs to the rest of the interface: memory-space response enable, bus-master enable and parity-error response enable. The bus-master enable also gates a local master-request flag. Parity-error events and the sampled level of the shared parity-error pin update the status flags. The block drives a single-clock active-low pulse onto the pin when responses are enabled. It also keeps a local parity-error flag, which raises a level interrupt toward the local processor when that processor has enabled it.

Top module: `pci_cmdstat`

## Requirements
- R1: The word is reachable only when `host_mode` equals 1 (PCI) and `cfg_addr` bits [7:2] equal 1 (byte offset 0x04). A read anywhere else returns zero, and a write anywhere else changes nothing.
- R2: A write updates only the byte lanes whose `cfg_be` bit is set; every other lane keeps its contents. A read returns the whole 32-bit word whatever `cfg_be` holds.
- R3: Word bit 1 is memory-space enable. It is read/write, is driven on `mem_space_en`, and resets to 0.
- R4: Word bit 2 is bus-master enable. It is read/write, is driven on `bus_master_en`, and resets to 0. While it is 0, `mreq_flag` is 0 in the same cycle.
- R5: Word bit 6 is parity-error response enable. It is read/write, is driven on `perr_resp_en`, and resets to 0. While it is 0, `perr_oe` stays low.
- R6: When `perr_detect` is high in a cycle with response enable set, `perr_oe` is 1 and `perr_n_out` is 0 for exactly the following clock. Otherwise `perr_oe` is 0.
- R7: Any `perr_detect` sets word bit 31 (detected parity error) and sets `lcl_perr_flag`, whatever the response enable holds.
- R8: With response enable set, a `perr_detect` or a low `perr_pin_in` sets word bit 24 (parity error reported). With the enable clear, neither event sets bit 24.
- R9: Bits 31 and 24 are write-one-to-clear through byte lane 3. Writing 0 leaves them unchanged, and a set event in the same cycle wins over the clear.
- R10: Word bit 7 and every other unimplemented command bit read as 0 and ignore writes.
- R11: `perr_irq` is high exactly while `lcl_perr_flag` and `lcl_perr_ie` are both high. `lcl_perr_clr` clears the flag unless a new parity error arrives in the same cycle.
- R12: With bus-master enable set, `mreq_set` sets `mreq_flag` and `mreq_clr` clears it. Set wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 3 | Interface mode; 1 selects PCI |
| cfg_rd | input | 1 | Configuration read in progress |
| cfg_wr | input | 1 | Configuration write in progress |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, zero when not selected |
| mem_space_en | output | 1 | Memory-space response enable |
| bus_master_en | output | 1 | Bus-master enable |
| perr_resp_en | output | 1 | Parity-error response enable |
| perr_detect | input | 1 | Parity error detected this cycle |
| perr_pin_in | input | 1 | Sampled level of the parity-error pin |
| perr_n_out | output | 1 | Parity-error pin drive value, active low |
| perr_oe | output | 1 | Parity-error pin output enable |
| lcl_perr_ie | input | 1 | Local parity-error interrupt enable |
| lcl_perr_clr | input | 1 | Local clear of the parity-error flag |
| lcl_perr_flag | output | 1 | Local parity-error flag |
| perr_irq | output | 1 | Parity-error interrupt request level |
| mreq_set | input | 1 | Request master operation |
| mreq_clr | input | 1 | Retire master request |
| mreq_flag | output | 1 | Local master-request flag |

## Verification
A wrong command bit appears on its control output one clock after the write. It also appears on the next configuration read. A lost or mistimed parity event shows up on the pin pair in the clock right after the detect cycle. It then remains visible as a stale or missing status bit or interrupt level until software clears it. A master-request flag that outlives its enable shows up in the same cycle that the enable drops. A wrong lane mask stays hidden until a later read returns a lane that should have been kept.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int unsigned HALF_W    = 16;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned HALF_LANES = HALF_W / LANE_W;
    localparam int unsigned MSE_POS   = 1;
    localparam int unsigned BME_POS   = 2;
    localparam int unsigned PERE_POS  = 6;
    localparam int unsigned DPR_POS   = 8;
    localparam int unsigned DPE_POS   = 15;
    localparam logic [HALF_W-1:0] CMD_RW_MASK =
        HALF_W'((1 << MSE_POS) | (1 << BME_POS) | (1 << PERE_POS));
    localparam logic [HALF_W-1:0] STAT_W1C_MASK =
        HALF_W'((1 << DPR_POS) | (1 << DPE_POS));

    typedef struct packed {
        logic [HALF_W-1:0] bits;
    } half_state_t;

    typedef struct packed {
        logic pulse;
        logic flag;
        logic mreq;
    } lcl_state_t;
endpackage

// File: rtl/pcs_cmd_half.sv
module pcs_cmd_half
    import pcs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [HALF_LANES-1:0] be,
    input  logic [HALF_W-1:0]     wdata,
    output logic [HALF_W-1:0]     cmd_q,
    output logic                  bme_next
);
    half_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int l = 0; l < HALF_LANES; l++) begin
                if (be[l]) begin
                    st_d.bits[l*LANE_W +: LANE_W] =
                        wdata[l*LANE_W +: LANE_W] & CMD_RW_MASK[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_q    = st_q.bits;
    assign bme_next = st_d.bits[BME_POS];
endmodule

// File: rtl/pcs_stat_half.sv
module pcs_stat_half
    import pcs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [HALF_LANES-1:0] be,
    input  logic [HALF_W-1:0]     wdata,
    input  logic                  resp_en,
    input  logic                  perr_detect,
    input  logic                  perr_pin_in,
    output logic [HALF_W-1:0]     stat_q
);
    half_state_t st_d, st_q;
    logic [HALF_W-1:0] clr_mask;
    logic [HALF_W-1:0] set_mask;

    always_comb begin
        clr_mask = '0;
        if (wr_en) begin
            for (int l = 0; l < HALF_LANES; l++) begin
                if (be[l]) clr_mask[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
            end
        end
        set_mask = '0;
        set_mask[DPE_POS] = perr_detect;
        set_mask[DPR_POS] = resp_en & (perr_detect | ~perr_pin_in);
        st_d.bits = ((st_q.bits & ~clr_mask) | set_mask) & STAT_W1C_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.bits;
endmodule

// File: rtl/pcs_local_side.sv
module pcs_local_side
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resp_en,
    input  logic bme_next,
    input  logic perr_detect,
    input  logic lcl_perr_ie,
    input  logic lcl_perr_clr,
    input  logic mreq_set,
    input  logic mreq_clr,
    output logic perr_n_out,
    output logic perr_oe,
    output logic lcl_perr_flag,
    output logic perr_irq,
    output logic mreq_flag
);
    lcl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = perr_detect & resp_en;
        st_d.flag  = perr_detect | (st_q.flag & ~lcl_perr_clr);
        st_d.mreq  = bme_next & (mreq_set | (st_q.mreq & ~mreq_clr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign perr_oe       = st_q.pulse;
    assign perr_n_out    = ~st_q.pulse;
    assign lcl_perr_flag = st_q.flag;
    assign perr_irq      = st_q.flag & lcl_perr_ie;
    assign mreq_flag     = st_q.mreq;
endmodule

// File: rtl/pci_cmdstat.sv
module pci_cmdstat
    import pcs_pkg::*;
#(
    parameter int unsigned          MODE_W     = 3,
    parameter logic [MODE_W-1:0]    PCI_MODE   = 1,
    parameter int unsigned          ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]    REG_OFFSET = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] host_mode,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_space_en,
    output logic              bus_master_en,
    output logic              perr_resp_en,
    input  logic              perr_detect,
    input  logic              perr_pin_in,
    output logic              perr_n_out,
    output logic              perr_oe,
    input  logic              lcl_perr_ie,
    input  logic              lcl_perr_clr,
    output logic              lcl_perr_flag,
    output logic              perr_irq,
    input  logic              mreq_set,
    input  logic              mreq_clr,
    output logic              mreq_flag
);
    localparam int unsigned DW_LSB = 2;

    logic              sel;
    logic              wr_hit;
    logic [HALF_W-1:0] cmd_q;
    logic [HALF_W-1:0] stat_q;
    logic              bme_next;

    assign sel    = (host_mode == PCI_MODE) &&
                    (cfg_addr[ADDR_W-1:DW_LSB] == REG_OFFSET[ADDR_W-1:DW_LSB]);
    assign wr_hit = sel & cfg_wr;

    pcs_cmd_half u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_hit),
        .be       (cfg_be[HALF_LANES-1:0]),
        .wdata    (cfg_wdata[HALF_W-1:0]),
        .cmd_q    (cmd_q),
        .bme_next (bme_next)
    );

    pcs_stat_half u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_hit),
        .be          (cfg_be[2*HALF_LANES-1:HALF_LANES]),
        .wdata       (cfg_wdata[2*HALF_W-1:HALF_W]),
        .resp_en     (cmd_q[PERE_POS]),
        .perr_detect (perr_detect),
        .perr_pin_in (perr_pin_in),
        .stat_q      (stat_q)
    );

    pcs_local_side u_lcl (
        .clk           (clk),
        .rst_n         (rst_n),
        .resp_en       (cmd_q[PERE_POS]),
        .bme_next      (bme_next),
        .perr_detect   (perr_detect),
        .lcl_perr_ie   (lcl_perr_ie),
        .lcl_perr_clr  (lcl_perr_clr),
        .mreq_set      (mreq_set),
        .mreq_clr      (mreq_clr),
        .perr_n_out    (perr_n_out),
        .perr_oe       (perr_oe),
        .lcl_perr_flag (lcl_perr_flag),
        .perr_irq      (perr_irq),
        .mreq_flag     (mreq_flag)
    );

    assign cfg_rdata     = (sel && cfg_rd) ? {stat_q, cmd_q} : '0;
    assign mem_space_en  = cmd_q[MSE_POS];
    assign bus_master_en = cmd_q[BME_POS];
    assign perr_resp_en  = cmd_q[PERE_POS];
endmodule

// File: rtl/pci_cmdstat_chk.sv
module pci_cmdstat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  host_mode,
    input logic [31:0] cfg_rdata,
    input logic        bus_master_en,
    input logic        perr_resp_en,
    input logic        perr_detect,
    input logic        perr_n_out,
    input logic        perr_oe,
    input logic        lcl_perr_ie,
    input logic        lcl_perr_flag,
    input logic        perr_irq,
    input logic        mreq_flag
);
    p_blocked_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode != 3'd1) |-> (cfg_rdata == 32'h0));

    p_mreq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_master_en |-> !mreq_flag);

    p_pin_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        perr_oe |-> ($past(perr_resp_en) && $past(perr_detect)));

    p_pin_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_detect && perr_resp_en) |=> (perr_oe && !perr_n_out));

    p_pin_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_oe |-> perr_n_out);

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        perr_detect |=> lcl_perr_flag);

    p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        perr_irq |-> (lcl_perr_ie && lcl_perr_flag));
endmodule

bind pci_cmdstat pci_cmdstat_chk chk_i (.*);

// File: tb/pci_cmdstat_tb_top.sv
module pci_cmdstat_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_mode = 3'd1;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h04;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic mem_space_en, bus_master_en, perr_resp_en;
    logic perr_detect = 1'b0, perr_pin_in = 1'b1;
    logic perr_n_out, perr_oe;
    logic lcl_perr_ie = 1'b0, lcl_perr_clr = 1'b0;
    logic lcl_perr_flag, perr_irq;
    logic mreq_set = 1'b0, mreq_clr = 1'b0;
    logic mreq_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pci_cmdstat dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] mode, input logic [7:0] addr,
                             input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_mode = mode; cfg_addr = addr; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; host_mode = 3'd1; cfg_addr = 8'h04;
    endtask

    task automatic cfg_read(input logic [2:0] mode, input logic [7:0] addr,
                            input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        host_mode = mode; cfg_addr = addr; cfg_be = be; cfg_rd = 1'b1;
        #2 d = cfg_rdata;
        cfg_rd = 1'b0; host_mode = 3'd1; cfg_addr = 8'h04;
    endtask

    // Detect pulse for one clock; returns at the negedge after it was sampled.
    task automatic detect_once();
        @(negedge clk); perr_detect = 1'b1;
        @(negedge clk); perr_detect = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R3 reset mse", 32'(mem_space_en), 0);
        chk("R4 reset bme", 32'(bus_master_en), 0);
        chk("R5 reset pere", 32'(perr_resp_en), 0);
        chk("R6 reset oe", 32'(perr_oe), 0);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R1 reset word", d, 32'h0);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        cfg_write(3'd0, 8'h04, 4'hF, 32'hFFFF_FFFF);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R1 write in other mode ignored", d, 32'h0);
        cfg_write(3'd1, 8'h08, 4'hF, 32'h0000_0046);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R1 write at other offset ignored", d, 32'h0);
        cfg_write(3'd1, 8'h04, 4'h1, 32'h0000_0002);
        chk("R3 mse output", 32'(mem_space_en), 1);
        cfg_read(3'd5, 8'h04, 4'hF, d);
        chk("R1 read in other mode", d, 32'h0);
        cfg_read(3'd1, 8'h00, 4'hF, d);
        chk("R1 read at other offset", d, 32'h0);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R3 mse readback", d, 32'h0000_0002);
    endtask

    task automatic t_cmd_bits();
        logic [31:0] d;
        cfg_write(3'd1, 8'h04, 4'h3, 32'h0000_FFFF);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R10 only bits 1,2,6 stick", d, 32'h0000_0046);
        chk("R10 bit7 zero", 32'(d[7]), 0);
        chk("R4 bme output", 32'(bus_master_en), 1);
        chk("R5 pere output", 32'(perr_resp_en), 1);
    endtask

    task automatic t_lanes();
        logic [31:0] d;
        cfg_write(3'd1, 8'h04, 4'hE, 32'h0000_0000);
        cfg_read(3'd1, 8'h04, 4'h0, d);
        chk("R2 disabled lane kept, full read", d, 32'h0000_0046);
        cfg_write(3'd1, 8'h04, 4'h1, 32'h0000_0004);
        cfg_read(3'd1, 8'h04, 4'h2, d);
        chk("R2 lane 0 written", d, 32'h0000_0004);
        chk("R3 mse cleared", 32'(mem_space_en), 0);
    endtask

    task automatic t_mreq();
        cfg_write(3'd1, 8'h04, 4'h1, 32'h0);
        @(negedge clk); mreq_set = 1'b1;
        @(negedge clk); mreq_set = 1'b0;
        chk("R4 mreq blocked without bme", 32'(mreq_flag), 0);
        cfg_write(3'd1, 8'h04, 4'h1, 32'h0000_0004);
        @(negedge clk); mreq_set = 1'b1;
        @(negedge clk); mreq_set = 1'b0;
        chk("R12 mreq set", 32'(mreq_flag), 1);
        @(negedge clk); mreq_clr = 1'b1; mreq_set = 1'b1;
        @(negedge clk); mreq_clr = 1'b0; mreq_set = 1'b0;
        chk("R12 set wins over clear", 32'(mreq_flag), 1);
        @(negedge clk); mreq_clr = 1'b1;
        @(negedge clk); mreq_clr = 1'b0;
        chk("R12 mreq cleared", 32'(mreq_flag), 0);
        @(negedge clk); mreq_set = 1'b1;
        @(negedge clk); mreq_set = 1'b0;
        cfg_write(3'd1, 8'h04, 4'h1, 32'h0);
        chk("R4 mreq dropped with bme", 32'(mreq_flag), 0);
    endtask

    task automatic t_parity_quiet();
        logic [31:0] d;
        lcl_perr_ie = 1'b0;
        detect_once();
        chk("R5 no pin drive when disabled", 32'(perr_oe), 0);
        chk("R7 local flag set", 32'(lcl_perr_flag), 1);
        chk("R11 irq masked", 32'(perr_irq), 0);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R7 DPE set, R8 DPR not set", d, 32'h8000_0000);
        @(negedge clk); lcl_perr_ie = 1'b1; #1;
        chk("R11 irq level", 32'(perr_irq), 1);
        @(negedge clk); lcl_perr_clr = 1'b1;
        @(negedge clk); lcl_perr_clr = 1'b0; #1;
        chk("R11 flag cleared", 32'(lcl_perr_flag), 0);
        chk("R11 irq dropped", 32'(perr_irq), 0);
        cfg_write(3'd1, 8'h04, 4'h8, 32'h8000_0000);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R9 DPE cleared by 1", d, 32'h0);
    endtask

    task automatic t_parity_resp();
        logic [31:0] d;
        cfg_write(3'd1, 8'h04, 4'h1, 32'h0000_0040);
        detect_once();
        chk("R6 pin enabled", 32'(perr_oe), 1);
        chk("R6 pin low", 32'(perr_n_out), 0);
        @(negedge clk); #1;
        chk("R6 pulse one clock", 32'(perr_oe), 0);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R8 DPR and DPE set", d, 32'h8100_0040);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        cfg_write(3'd1, 8'h04, 4'h8, 32'h0000_0000);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R9 zero write keeps", d, 32'h8100_0040);
        cfg_write(3'd1, 8'h04, 4'h7, 32'hFF00_0040);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R9 lane 3 disabled keeps", d, 32'h8100_0040);
        cfg_write(3'd1, 8'h04, 4'h8, 32'h0100_0000);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R9 DPR cleared alone", d, 32'h8000_0040);
        @(negedge clk);
        cfg_be = 4'h8; cfg_wdata = 32'h8100_0000; cfg_wr = 1'b1; perr_detect = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; perr_detect = 1'b0;
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R9 set wins over clear", d, 32'h8100_0040);
    endtask

    task automatic t_pin();
        logic [31:0] d;
        cfg_write(3'd1, 8'h04, 4'h8, 32'h8100_0000);
        @(negedge clk); lcl_perr_clr = 1'b1;
        @(negedge clk); lcl_perr_clr = 1'b0; perr_pin_in = 1'b0;
        @(negedge clk); perr_pin_in = 1'b1; #1;
        chk("R8 pin low leaves flag", 32'(lcl_perr_flag), 0);
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R8 pin low sets DPR only", d, 32'h0100_0040);
        cfg_write(3'd1, 8'h04, 4'h9, 32'h0100_0000);
        @(negedge clk); perr_pin_in = 1'b0;
        @(negedge clk); perr_pin_in = 1'b1;
        cfg_read(3'd1, 8'h04, 4'hF, d);
        chk("R8 pin low ignored when disabled", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gating();
        t_cmd_bits();
        t_lanes();
        t_mreq();
        t_parity_quiet();
        t_parity_resp();
        t_w1c();
        t_pin();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule